// File: doc/BRIEF.md
# Width-Aliased General Register File

This block holds sixteen 64-bit general registers, each one reachable at 1, 2, 4 or 8 byte width. Every width is a view of the same 64-bit storage: a narrow read sees the low bits of the full value, and a narrow write lands in the low bits. The write width decides what happens to the untouched upper bits. A 4-byte write clears bits 63:32. A 1-byte or 2-byte write keeps everything above the lane it writes.

The write path also shapes the incoming value before it is merged into the destination. It can widen a narrow source with zero fill or with sign fill. It can take an immediate either whole, or as its low 32 bits sign-extended to 64. Two combinational read ports serve operand fetch. Register 4 serves as the stack pointer and is also driven out on its own port.

Top module: `gpr_alias_file`

## Requirements
- R1: The 2-bit size code selects 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A read returns the low 8/16/32/64 bits of the addressed register, with all higher output bits zero.
- R2: A write at size 0 or size 1 replaces only bits 7:0 or bits 15:0 of the destination. All higher bits keep their previous value.
- R3: A write at size 2 stores bits 31:0 of the shaped value and forces bits 63:32 of the destination to zero.
- R4: A plain move (mode 0) at size 3 stores all 64 bits of the write data.
- R5: Zero-extend mode (mode 1) takes the low bits of the write data at the source size (`wr_src_size`), fills the bits above them with zeros, and then writes the result at the destination size under R2/R3.
- R6: Sign-extend mode (mode 2) behaves like R5, except that every bit above the source width is filled with the source's top bit.
- R7: Immediate mode (mode 3) with `wr_imm_full` = 0 sign-extends bits 31:0 of the write data to 64 bits before the destination-size rules apply. For example, 0x0011223344556677 written at size 3 gives 0x0000000044556677.
- R8: Immediate mode with `wr_imm_full` = 1 writes the 64-bit data unchanged.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the value held before the clock edge. The new value becomes visible right after that edge.
- R10: An active-low reset clears every register to zero.
- R11: `sp_value` always shows the full 64-bit content of register 4.
- R12: When `wr_en` is low, no register changes.
- R13: In an extend mode, a source size that is not smaller than the destination size acts as a plain move of the data at the destination size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 64 | Read port A data, zero above the selected width |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 64 | Read port B data, zero above the selected width |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Destination register index |
| wr_size | input | 2 | Destination size code |
| wr_src_size | input | 2 | Source size code for the extend modes |
| wr_mode | input | 2 | 0 move, 1 zero-extend, 2 sign-extend, 3 immediate |
| wr_imm_full | input | 1 | In immediate mode: 1 takes all 64 bits, 0 takes 32 bits sign-extended |
| wr_data | input | 64 | Write data or immediate |
| sp_value | output | 64 | Full content of register 4 |

## Verification
Read results depend only on the inputs, so they are due in the same cycle the index and size are applied. A write is due in the storage at the rising edge that samples it, and it shows on the read ports and `sp_value` straight after that edge. The bench drives every input on the falling edge. It samples write results 1 ns after the following rising edge, and it samples the old value of a register being written in the same cycle before that rising edge. Each table entry writes once and reads back after that edge, so every merge case sees the value left by the entry before it.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } gpr_size_e;

   typedef enum logic [1:0] {
      WM_MOVE = 2'd0,
      WM_ZEXT = 2'd1,
      WM_SEXT = 2'd2,
      WM_IMM  = 2'd3
   } gpr_wmode_e;

   localparam int unsigned GPR_WORD_BITS = 64;

   // Mask covering the low lane of the given size code.
   function automatic logic [GPR_WORD_BITS-1:0] lane_mask(input logic [1:0] sz);
      logic [GPR_WORD_BITS-1:0] m;
      case (sz)
         2'd0:    m = 64'h0000_0000_0000_00FF;
         2'd1:    m = 64'h0000_0000_0000_FFFF;
         2'd2:    m = 64'h0000_0000_FFFF_FFFF;
         default: m = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
      return m;
   endfunction

   // Top bit of the low lane of the given size code.
   function automatic logic lane_msb(input logic [GPR_WORD_BITS-1:0] v, input logic [1:0] sz);
      logic b;
      case (sz)
         2'd0:    b = v[7];
         2'd1:    b = v[15];
         2'd2:    b = v[31];
         default: b = v[63];
      endcase
      return b;
   endfunction

endpackage

// File: rtl/gpr_src_shaper.sv
module gpr_src_shaper
   import gpr_alias_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] data_in,
   input  logic [1:0]      src_size,
   input  logic [1:0]      dst_size,
   input  logic [1:0]      mode,
   input  logic            imm_full,
   output logic [XLEN-1:0] shaped
);

   localparam int unsigned HALF = XLEN / 2;

   logic [XLEN-1:0] src_mask;
   logic            fill_bit;
   logic            widen;
   logic [XLEN-1:0] ext_val;
   logic [XLEN-1:0] imm_val;

   always_comb begin
      src_mask = lane_mask(src_size);
      widen    = (src_size < dst_size);
      fill_bit = (mode == WM_SEXT) ? lane_msb(data_in, src_size) : 1'b0;
      ext_val  = widen ? ((data_in & src_mask) | ({XLEN{fill_bit}} & ~src_mask)) : data_in;
      imm_val  = imm_full ? data_in : {{HALF{data_in[HALF-1]}}, data_in[HALF-1:0]};
   end

   always_comb begin
      case (mode)
         WM_ZEXT, WM_SEXT: shaped = ext_val;
         WM_IMM:           shaped = imm_val;
         default:          shaped = data_in;
      endcase
   end

endmodule

// File: rtl/gpr_width_merge.sv
module gpr_width_merge
   import gpr_alias_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter bit          CLEAR_ON_LONG = 1'b1
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] new_val,
   input  logic [1:0]      dst_size,
   output logic [XLEN-1:0] merged
);

   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] keep_mask;

   assign mask = lane_mask(dst_size);

   generate
      if (CLEAR_ON_LONG) begin : g_long_clears
         // 4-byte writes drop the old upper half; narrower writes keep it.
         always_comb begin
            if (dst_size == SZ_LONG || dst_size == SZ_QUAD) keep_mask = '0;
            else                                           keep_mask = ~mask;
         end
      end else begin : g_long_merges
         always_comb keep_mask = ~mask;
      end
   endgenerate

   assign merged = (old_val & keep_mask) | (new_val & mask);

endmodule

// File: rtl/gpr_read_view.sv
module gpr_read_view
   import gpr_alias_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] reg_val,
   input  logic [1:0]      size,
   output logic [XLEN-1:0] view
);

   assign view = reg_val & lane_mask(size);

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
   import gpr_alias_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned NREGS    = 16,
   parameter int unsigned SP_INDEX = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  rd_a_idx,
   input  logic [1:0]  rd_a_size,
   output logic [63:0] rd_a_data,
   input  logic [3:0]  rd_b_idx,
   input  logic [1:0]  rd_b_size,
   output logic [63:0] rd_b_data,
   input  logic        wr_en,
   input  logic [3:0]  wr_idx,
   input  logic [1:0]  wr_size,
   input  logic [1:0]  wr_src_size,
   input  logic [1:0]  wr_mode,
   input  logic        wr_imm_full,
   input  logic [63:0] wr_data,
   output logic [63:0] sp_value
);

   localparam int unsigned IDX_W = $clog2(NREGS);
   localparam int unsigned NRD   = 2;

   generate
      if (XLEN != GPR_WORD_BITS) begin : g_bad_xlen
         $error("gpr_alias_file: XLEN must equal 64 for the four size codes");
      end
      if (NREGS != 16) begin : g_bad_nregs
         $error("gpr_alias_file: index ports are 4 bits, NREGS must be 16");
      end
      if (SP_INDEX >= NREGS) begin : g_bad_sp
         $error("gpr_alias_file: SP_INDEX outside the register file");
      end
   endgenerate

   logic [XLEN-1:0] regs_q [NREGS];
   logic [XLEN-1:0] shaped;
   logic [XLEN-1:0] merged;
   logic [XLEN-1:0] old_dst;

   logic [IDX_W-1:0] rd_idx  [NRD];
   logic [1:0]       rd_size [NRD];
   logic [XLEN-1:0]  rd_view [NRD];

   assign rd_idx[0]  = rd_a_idx;
   assign rd_idx[1]  = rd_b_idx;
   assign rd_size[0] = rd_a_size;
   assign rd_size[1] = rd_b_size;
   assign rd_a_data  = rd_view[0];
   assign rd_b_data  = rd_view[1];

   gpr_src_shaper #(.XLEN(XLEN)) shaper_i (
      .data_in  (wr_data),
      .src_size (wr_src_size),
      .dst_size (wr_size),
      .mode     (wr_mode),
      .imm_full (wr_imm_full),
      .shaped   (shaped)
   );

   assign old_dst = regs_q[wr_idx];

   gpr_width_merge #(.XLEN(XLEN), .CLEAR_ON_LONG(1'b1)) merge_i (
      .old_val  (old_dst),
      .new_val  (shaped),
      .dst_size (wr_size),
      .merged   (merged)
   );

   generate
      for (genvar r = 0; r < NREGS; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   regs_q[r] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(r)))      regs_q[r] <= merged;
         end
      end

      for (genvar p = 0; p < NRD; p++) begin : g_rd
         gpr_read_view #(.XLEN(XLEN)) view_i (
            .reg_val (regs_q[rd_idx[p]]),
            .size    (rd_size[p]),
            .view    (rd_view[p])
         );
      end
   endgenerate

   assign sp_value = regs_q[SP_INDEX];

endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk
   import gpr_alias_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned NREGS    = 16,
   parameter int unsigned SP_INDEX = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      rd_a_idx,
   input logic [1:0]      rd_a_size,
   input logic [63:0]     rd_a_data,
   input logic            wr_en,
   input logic [3:0]      wr_idx,
   input logic [1:0]      wr_size,
   input logic [1:0]      wr_src_size,
   input logic [1:0]      wr_mode,
   input logic            wr_imm_full,
   input logic [63:0]     wr_data,
   input logic [63:0]     sp_value,
   input logic [XLEN-1:0] regs_q [NREGS]
);

   p_quad_view_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_size == SZ_QUAD) |-> (rd_a_data == regs_q[rd_a_idx]));

   p_byte_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == SZ_BYTE)
      |=> (regs_q[$past(wr_idx)][63:8] == $past(regs_q[wr_idx][63:8])));

   p_long_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == SZ_LONG) |=> (regs_q[$past(wr_idx)][63:32] == 32'h0));

   p_sext_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WM_SEXT && wr_src_size == SZ_BYTE && wr_size == SZ_QUAD && wr_data[7])
      |=> (regs_q[$past(wr_idx)][63:8] == 56'hFF_FFFF_FFFF_FFFF));

   p_short_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WM_IMM && !wr_imm_full && wr_size == SZ_QUAD)
      |=> (regs_q[$past(wr_idx)][63:32] == {32{$past(wr_data[31])}}));

   p_full_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_mode == WM_IMM && wr_imm_full && wr_size == SZ_QUAD)
      |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

   p_sp_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sp_value == regs_q[SP_INDEX]);

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (regs_q[$past(rd_a_idx)] == $past(regs_q[rd_a_idx])));

endmodule

bind gpr_alias_file gpr_alias_file_chk #(
   .XLEN(XLEN), .NREGS(NREGS), .SP_INDEX(SP_INDEX)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_a_idx    (rd_a_idx),
   .rd_a_size   (rd_a_size),
   .rd_a_data   (rd_a_data),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_size     (wr_size),
   .wr_src_size (wr_src_size),
   .wr_mode     (wr_mode),
   .wr_imm_full (wr_imm_full),
   .wr_data     (wr_data),
   .sp_value    (sp_value),
   .regs_q      (regs_q)
);

// File: tb/gpr_alias_file_tb.sv
`timescale 1ns/1ps
module gpr_alias_file_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0;
   logic [1:0]  rd_a_size = '0;
   logic [63:0] rd_a_data;
   logic [3:0]  rd_b_idx = '0;
   logic [1:0]  rd_b_size = '0;
   logic [63:0] rd_b_data;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [1:0]  wr_size = '0;
   logic [1:0]  wr_src_size = '0;
   logic [1:0]  wr_mode = '0;
   logic        wr_imm_full = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] sp_value;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   gpr_alias_file dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_src_size(wr_src_size),
      .wr_mode(wr_mode), .wr_imm_full(wr_imm_full), .wr_data(wr_data),
      .sp_value(sp_value)
   );

   typedef struct packed {
      logic        we;
      logic [3:0]  idx;
      logic [1:0]  sz;
      logic [1:0]  src;
      logic [1:0]  mode;
      logic        full;
      logic [1:0]  rsz;
      logic [63:0] data;
      logic [63:0] expv;
   } vec_t;

   localparam int NV = 25;
   // sizes: 0 byte, 1 word, 2 long, 3 quad; modes: 0 move, 1 zext, 2 sext, 3 imm
   localparam vec_t TBL [NV] = '{
      '{1'b1, 4'd1, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R4
      '{1'b1, 4'd1, 2'd0, 2'd3, 2'd0, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFF55, 64'h0123456789ABCD55}, // R2
      '{1'b1, 4'd1, 2'd1, 2'd3, 2'd0, 1'b0, 2'd3, 64'h111122223333BEEF, 64'h0123456789ABBEEF}, // R2
      '{1'b1, 4'd1, 2'd2, 2'd3, 2'd0, 1'b0, 2'd3, 64'hAAAABBBBCCCCDDDD, 64'h00000000CCCCDDDD}, // R3
      '{1'b0, 4'd1, 2'd3, 2'd3, 2'd0, 1'b0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 64'h00000000000000DD}, // R1 R12
      '{1'b0, 4'd1, 2'd3, 2'd3, 2'd0, 1'b0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 64'h000000000000DDDD}, // R1 R12
      '{1'b0, 4'd1, 2'd3, 2'd3, 2'd0, 1'b0, 2'd2, 64'hFFFFFFFFFFFFFFFF, 64'h00000000CCCCDDDD}, // R1 R12
      '{1'b1, 4'd2, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, // R4
      '{1'b1, 4'd2, 2'd3, 2'd0, 2'd1, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFF80, 64'h0000000000000080}, // R5
      '{1'b1, 4'd2, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, // R4
      '{1'b1, 4'd2, 2'd1, 2'd0, 2'd1, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFF80, 64'hFFFFFFFFFFFF0080}, // R5
      '{1'b1, 4'd2, 2'd2, 2'd1, 2'd1, 1'b0, 2'd3, 64'hFFFFFFFFFFFF9234, 64'h0000000000009234}, // R5
      '{1'b1, 4'd5, 2'd3, 2'd0, 2'd2, 1'b0, 2'd3, 64'h0000000000000080, 64'hFFFFFFFFFFFFFF80}, // R6
      '{1'b1, 4'd5, 2'd3, 2'd0, 2'd2, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFF7F, 64'h000000000000007F}, // R6
      '{1'b1, 4'd5, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'h0000000000000000, 64'h0000000000000000}, // R4
      '{1'b1, 4'd5, 2'd1, 2'd0, 2'd2, 1'b0, 2'd3, 64'h00000000000000F0, 64'h000000000000FFF0}, // R6
      '{1'b1, 4'd5, 2'd2, 2'd1, 2'd2, 1'b0, 2'd3, 64'h0000000000008001, 64'h00000000FFFF8001}, // R6
      '{1'b1, 4'd6, 2'd3, 2'd1, 2'd2, 1'b0, 2'd3, 64'h0000000000008001, 64'hFFFFFFFFFFFF8001}, // R6
      '{1'b1, 4'd7, 2'd3, 2'd0, 2'd3, 1'b0, 2'd3, 64'h0011223344556677, 64'h0000000044556677}, // R7
      '{1'b1, 4'd7, 2'd3, 2'd0, 2'd3, 1'b0, 2'd3, 64'h0000000080000000, 64'hFFFFFFFF80000000}, // R7
      '{1'b1, 4'd7, 2'd3, 2'd0, 2'd3, 1'b1, 2'd3, 64'h0011223344556677, 64'h0011223344556677}, // R8
      '{1'b1, 4'd7, 2'd0, 2'd0, 2'd3, 1'b0, 2'd3, 64'h00000000000000AB, 64'h00112233445566AB}, // R7
      '{1'b1, 4'd9, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF}, // R4
      '{1'b1, 4'd9, 2'd1, 2'd2, 2'd1, 1'b0, 2'd3, 64'h0000000012348765, 64'hFFFFFFFFFFFF8765}, // R13
      '{1'b1, 4'd4, 2'd3, 2'd3, 2'd0, 1'b0, 2'd3, 64'h0000000000008000, 64'h0000000000008000}  // R11
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state, both read ports
      for (int i = 0; i < 16; i++) begin
         rd_a_idx = 4'(i); rd_a_size = 2'd3;
         rd_b_idx = 4'(15 - i); rd_b_size = 2'd3;
         #1;
         check("R10 port A after reset", rd_a_data, 64'h0);
         check("R10 port B after reset", rd_b_data, 64'h0);
      end
      check("R10 sp after reset", sp_value, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: write at the falling edge, read back after the next rising edge
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         wr_en = TBL[v].we; wr_idx = TBL[v].idx; wr_size = TBL[v].sz;
         wr_src_size = TBL[v].src; wr_mode = TBL[v].mode; wr_imm_full = TBL[v].full;
         wr_data = TBL[v].data;
         rd_a_idx = TBL[v].idx; rd_a_size = TBL[v].rsz;
         @(posedge clk);
         #1;
         check($sformatf("table entry %0d (R1-R8 R12 R13 set)", v), rd_a_data, TBL[v].expv);
      end
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check("R11 sp output after stack write", sp_value, 64'h0000000000008000);

      // R1 port B views of register 1
      rd_b_idx = 4'd1; rd_b_size = 2'd1; #1;
      check("R1 port B word view", rd_b_data, 64'h000000000000DDDD);
      rd_b_size = 2'd0; #1;
      check("R1 port B byte view", rd_b_data, 64'h00000000000000DD);

      // R12: write data presented with enable low leaves register 2 alone
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 4'd2; wr_size = 2'd3; wr_mode = 2'd0; wr_data = 64'hDEADBEEFDEADBEEF;
      rd_a_idx = 4'd2; rd_a_size = 2'd3;
      @(posedge clk); #1;
      check("R12 no write when disabled", rd_a_data, 64'h0000000000009234);

      // R9: same-cycle read returns old value, new value after the edge
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd8; wr_size = 2'd3; wr_src_size = 2'd3; wr_mode = 2'd0;
      wr_imm_full = 1'b0; wr_data = 64'h5555AAAA5555AAAA;
      rd_a_idx = 4'd8; rd_a_size = 2'd3;
      #1;
      check("R9 old value before edge", rd_a_data, 64'h0);
      @(posedge clk); #1;
      check("R9 new value after edge", rd_a_data, 64'h5555AAAA5555AAAA);
      @(negedge clk);
      wr_en = 1'b0;

      // R10: reset in the middle of a run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_a_idx = 4'd8; rd_a_size = 2'd3; rd_b_idx = 4'd1; rd_b_size = 2'd3;
      #1;
      check("R10 port A after mid-run reset", rd_a_data, 64'h0);
      check("R10 port B after mid-run reset", rd_b_data, 64'h0);
      check("R10 sp after mid-run reset", sp_value, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule